// File: doc/BRIEF.md
# Sweep Sensor Frame Aligner

This block sits behind the byte interface of a swept thermal fingerprint strip sensor. The sensor sends an endless stream of bytes. Each byte packs two 4-bit pixels: the upper nibble holds an odd-row pixel and the lower nibble holds the even-row pixel of the same pair. The frame has no explicit start marker. The only way to find the frame boundary is the last column of each frame, a four-byte filler column. Its first two bytes carry a fixed pattern with one don't-care bit. Its last two bytes carry four telemetry nibbles.

The aligner compares every pair of adjacent accepted bytes against that pattern. It takes a hit as a candidate frame phase and confirms the candidate when the pattern returns exactly one frame length later. Once it is locked, the block tags every image byte with its column and pair index. It splits the byte into two pixels, each labelled with its row number. At the end of each frame it publishes the four telemetry nibbles together with a one-cycle done pulse. Lock survives a single lost pattern and is released after two consecutive misses. The downstream logic that stitches the slices into an image consumes the tagged pixels directly.

Top module: `sweep_frame_aligner`

## Requirements
- R1: While `rst_n` is sampled low, the block holds `locked`, `px_valid` and `frame_done` low and all four telemetry outputs at zero.
- R2: A byte matches the pattern when bits [7:5] are 111 and bits [3:0] are 0000; bit 4 is ignored. A signature is two consecutive accepted matching bytes. The second of them is frame position 1121, counting from position 0, in a frame of 1124 bytes.
- R3: From the unlocked state, a signature makes a candidate. `locked` rises in the cycle after the byte that completes a second signature exactly 1124 accepted bytes after the first.
- R4: When locked, one missing signature at the expected position keeps lock. Two consecutive missing signatures clear `locked` in the cycle after the second miss.
- R5: No pixel is reported (`px_valid` stays low) for bytes accepted while unlocked.
- R6: Frame positions 0 to 1119 are image bytes. Position p is reported with `col` = p/4 + 1 (1 to 280) and pair index p mod 4.
- R7: For pair index k, `px_odd` is byte bits [7:4] with `row_odd` = 2k+1, and `px_even` is bits [3:0] with `row_even` = 2k+2.
- R8: When locked, `frame_done` pulses for one cycle after frame position 1123 is accepted. In the same cycle the telemetry outputs update: `tel_r` = byte 1122 bits [7:4], `tel_n` = byte 1122 bits [3:0], `tel_t` = byte 1123 bits [7:4], `tel_p` = byte 1123 bits [3:0]. They hold their value until the next pulse.
- R9: Cycles with `in_valid` low are ignored: the frame position does not advance, no pixel or done pulse is produced, and their byte value cannot form part of a signature.
- R10: Pixel outputs are registered and describe the byte accepted at the previous rising clock edge.
- R11: A candidate whose second signature is missing one frame later is discarded. The block returns to searching without locking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_byte` in this cycle |
| in_byte | input | 8 | Sensor byte: odd pixel in [7:4], even pixel in [3:0] |
| locked | output | 1 | Frame phase confirmed |
| px_valid | output | 1 | Pixel pair outputs carry an image byte |
| px_odd | output | 4 | Odd-row pixel value |
| px_even | output | 4 | Even-row pixel value |
| row_odd | output | 4 | Row number of `px_odd` (1, 3, 5, 7) |
| row_even | output | 4 | Row number of `px_even` (2, 4, 6, 8) |
| col | output | 9 | Column number, 1 to 280 |
| frame_done | output | 1 | One-cycle pulse at the end of a locked frame |
| tel_r | output | 4 | Telemetry nibble, third filler byte, upper half |
| tel_n | output | 4 | Telemetry nibble, third filler byte, lower half |
| tel_t | output | 4 | Telemetry nibble, fourth filler byte, upper half |
| tel_p | output | 4 | Telemetry nibble, fourth filler byte, lower half |

## Verification
The embedded properties watch several rules on every cycle:
- lock only rises right after a detected signature;
- lock only falls right after an accepted byte at the expected position that carried no signature;
- pixels only appear for accepted bytes taken while locked;
- columns stay within 1 to 280;
- the done pulse never coincides with a pixel.

Some behaviour is only visible in the bench scenarios:
- the exact acquisition and loss sequence across patterns that differ only in the don't-care bit or in one significant bit;
- the column and row labels and nibble values for every image byte;
- the telemetry contents;
- the discarding of a false candidate;
- the insensitivity to idle cycles that present a matching byte value.

// File: rtl/sfa_pkg.sv
// Shared definitions for the sweep frame aligner.
// Assumes the signature byte layout: bits [7:5] set, bit 4 free, bits [3:0] clear.
package sfa_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_t;

    localparam logic [7:0] SIG_MASK  = 8'hEF;
    localparam logic [7:0] SIG_VALUE = 8'hE0;

    // True when a byte carries the filler-column pattern (bit 4 ignored).
    function automatic logic sig_byte_match(input logic [7:0] b);
        return (b & SIG_MASK) == SIG_VALUE;
    endfunction

endpackage

// File: rtl/sfa_sig_detect.sv
// Sliding two-byte signature comparator.
// Raises sig_hit_o combinationally on an accepted byte that matches the
// pattern when the previously accepted byte matched as well.
// Assumes bytes are only meaningful when in_valid_i is high.
module sfa_sig_detect
    import sfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid_i,
    input  logic [7:0] in_byte_i,
    output logic       sig_hit_o
);

    logic prev_match_q;
    logic cur_match;

    // Pattern test of the byte currently presented.
    always_comb cur_match = sig_byte_match(in_byte_i);

    // Remember whether the last accepted byte matched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_match_q <= 1'b0;
        end else if (in_valid_i) begin
            prev_match_q <= cur_match;
        end
    end

    // Signature completes on the second of two matching accepted bytes.
    always_comb sig_hit_o = in_valid_i && prev_match_q && cur_match;

endmodule

// File: rtl/sfa_lock_ctrl.sv
// Frame phase tracker and lock state machine.
// Keeps pos_o, the frame position of the byte presented now. It jumps to the
// signature phase when a candidate is taken and otherwise wraps every frame.
// Lock needs two signatures one frame apart. Lock is released after MISS_LIMIT
// consecutive missing signatures.
// Assumes sig_hit_i is qualified by in_valid_i.
module sfa_lock_ctrl
    import sfa_pkg::*;
#(
    parameter int FRAME_BYTES = 1124,
    parameter int SIG_POS     = 1121,
    parameter int MISS_LIMIT  = 2,
    parameter int POS_W       = $clog2(FRAME_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic             sig_hit_i,
    output logic [POS_W-1:0] pos_o,
    output logic             locked_o
);

    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(FRAME_BYTES - 1);
    localparam logic [POS_W-1:0]  SIG_AT    = POS_W'(SIG_POS);
    localparam logic [POS_W-1:0]  AFTER_SIG = POS_W'(SIG_POS + 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    lock_state_t       state_q, state_d;
    logic [POS_W-1:0]  pos_q, pos_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic              at_sig;

    // Is the byte presented now at the expected signature slot.
    always_comb at_sig = (pos_q == SIG_AT);

    // Next frame position: re-phase on a new candidate, else wrap-increment.
    always_comb begin
        pos_d = pos_q;
        if (in_valid_i) begin
            if (state_q == ST_SEARCH && sig_hit_i) begin
                pos_d = AFTER_SIG;
            end else if (pos_q == LAST_POS) begin
                pos_d = '0;
            end else begin
                pos_d = pos_q + 1'b1;
            end
        end
    end

    // Lock state transitions, evaluated only on accepted bytes.
    always_comb begin
        state_d = state_q;
        miss_d  = miss_q;
        if (in_valid_i) begin
            unique case (state_q)
                ST_SEARCH: begin
                    if (sig_hit_i) begin
                        state_d = ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (at_sig) begin
                        state_d = sig_hit_i ? ST_LOCKED : ST_SEARCH;
                        miss_d  = '0;
                    end
                end
                ST_LOCKED: begin
                    if (at_sig) begin
                        if (sig_hit_i) begin
                            miss_d = '0;
                        end else if (miss_q == MISS_LAST) begin
                            state_d = ST_SEARCH;
                            miss_d  = '0;
                        end else begin
                            miss_d = miss_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_SEARCH;
                    miss_d  = '0;
                end
            endcase
        end
    end

    // State, position and miss counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            pos_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            miss_q  <= miss_d;
        end
    end

    // Export position of the presented byte and the lock flag.
    always_comb begin
        pos_o    = pos_q;
        locked_o = (state_q == ST_LOCKED);
    end

    AST_LOCK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(sig_hit_i)); // R3

    AST_DROP_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(locked_o) && $past(rst_n)) |-> $past(in_valid_i && at_sig && !sig_hit_i)); // R4

    AST_IDLE_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid_i && locked_o) |=> locked_o); // R9

endmodule

// File: rtl/sfa_unpack.sv
// Image byte unpacker and telemetry latch.
// Converts the frame position of an accepted byte into a column number and
// a pair index. It splits the byte into odd-row and even-row pixels with their
// row numbers, and captures the two telemetry bytes of the filler column.
// Assumes pos_i and locked_i describe the byte presented in this cycle.
module sfa_unpack #(
    parameter int N_COLS = 280,
    parameter int PAIRS  = 4,
    parameter int POS_W  = 11,
    parameter int COL_W  = 9,
    parameter int ROW_W  = 4,
    parameter int NIB_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [2*NIB_W-1:0] in_byte_i,
    input  logic [POS_W-1:0]   pos_i,
    input  logic               locked_i,
    output logic               px_valid_o,
    output logic [NIB_W-1:0]   px_odd_o,
    output logic [NIB_W-1:0]   px_even_o,
    output logic [ROW_W-1:0]   row_odd_o,
    output logic [ROW_W-1:0]   row_even_o,
    output logic [COL_W-1:0]   col_o,
    output logic               frame_done_o,
    output logic [NIB_W-1:0]   tel_r_o,
    output logic [NIB_W-1:0]   tel_n_o,
    output logic [NIB_W-1:0]   tel_t_o,
    output logic [NIB_W-1:0]   tel_p_o
);

    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int IMG_BYTES = N_COLS * PAIRS;
    localparam logic [POS_W-1:0] IMG_END = POS_W'(IMG_BYTES);
    localparam logic [POS_W-1:0] TEL_A   = POS_W'(IMG_BYTES + 2);
    localparam logic [POS_W-1:0] TEL_B   = POS_W'(IMG_BYTES + 3);

    logic [COL_W-1:0]    col_calc;
    logic [PAIR_W-1:0]   pair_calc;
    logic                take_px;
    logic                take_a;
    logic                take_b;
    logic [2*NIB_W-1:0]  tel_a_stage_q;

    // Column and pair from position: shift for power-of-two pairs, else divide.
    generate
        if ((PAIRS & (PAIRS - 1)) == 0) begin : g_shift
            assign col_calc  = COL_W'((pos_i >> PAIR_W) + 1'b1);
            assign pair_calc = pos_i[PAIR_W-1:0];
        end else begin : g_div
            assign col_calc  = COL_W'(32'(pos_i) / PAIRS + 1);
            assign pair_calc = PAIR_W'(32'(pos_i) % PAIRS);
        end
    endgenerate

    // Qualify image and telemetry bytes of a locked frame.
    always_comb begin
        take_px = in_valid_i && locked_i && (pos_i < IMG_END);
        take_a  = in_valid_i && locked_i && (pos_i == TEL_A);
        take_b  = in_valid_i && locked_i && (pos_i == TEL_B);
    end

    // Registered pixel pair with row and column labels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_valid_o <= 1'b0;
            px_odd_o   <= '0;
            px_even_o  <= '0;
            row_odd_o  <= '0;
            row_even_o <= '0;
            col_o      <= '0;
        end else begin
            px_valid_o <= take_px;
            if (take_px) begin
                px_odd_o   <= in_byte_i[2*NIB_W-1:NIB_W];
                px_even_o  <= in_byte_i[NIB_W-1:0];
                row_odd_o  <= ROW_W'({pair_calc, 1'b1});
                row_even_o <= ROW_W'({pair_calc, 1'b0}) + ROW_W'(2);
                col_o      <= col_calc;
            end
        end
    end

    // Stage the first telemetry byte, publish both with the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tel_a_stage_q <= '0;
            frame_done_o  <= 1'b0;
            tel_r_o       <= '0;
            tel_n_o       <= '0;
            tel_t_o       <= '0;
            tel_p_o       <= '0;
        end else begin
            frame_done_o <= take_b;
            if (take_a) begin
                tel_a_stage_q <= in_byte_i;
            end
            if (take_b) begin
                tel_r_o <= tel_a_stage_q[2*NIB_W-1:NIB_W];
                tel_n_o <= tel_a_stage_q[NIB_W-1:0];
                tel_t_o <= in_byte_i[2*NIB_W-1:NIB_W];
                tel_p_o <= in_byte_i[NIB_W-1:0];
            end
        end
    end

    AST_PX_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid_o |-> $past(locked_i)); // R5

    AST_PX_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid_o |-> $past(in_valid_i)); // R9

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid_o |-> (col_o >= COL_W'(1) && col_o <= COL_W'(N_COLS))); // R6

    AST_DONE_NOT_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> !px_valid_o); // R8

    AST_TEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done_o && $past(rst_n)) |-> $stable({tel_r_o, tel_n_o, tel_t_o, tel_p_o})); // R8

endmodule

// File: rtl/sweep_frame_aligner.sv
// Top level of the sweep sensor frame aligner.
// Finds the frame phase from the filler-column signature and locks to it.
// While locked, labels image bytes with column and row, splits them into
// pixels, and reports the filler-column telemetry once per frame.
// Assumes one sensor byte per cycle at most, qualified by in_valid.
module sweep_frame_aligner #(
    parameter int N_COLS      = 280,
    parameter int PAIRS       = 4,
    parameter int FILLER_LEN  = 4,
    parameter int MISS_LIMIT  = 2,
    localparam int NIB_W       = 4,
    localparam int FRAME_BYTES = N_COLS * PAIRS + FILLER_LEN,
    localparam int POS_W       = $clog2(FRAME_BYTES),
    localparam int COL_W       = $clog2(N_COLS + 1),
    localparam int ROW_W       = $clog2(2 * PAIRS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2*NIB_W-1:0] in_byte,
    output logic               locked,
    output logic               px_valid,
    output logic [NIB_W-1:0]   px_odd,
    output logic [NIB_W-1:0]   px_even,
    output logic [ROW_W-1:0]   row_odd,
    output logic [ROW_W-1:0]   row_even,
    output logic [COL_W-1:0]   col,
    output logic               frame_done,
    output logic [NIB_W-1:0]   tel_r,
    output logic [NIB_W-1:0]   tel_n,
    output logic [NIB_W-1:0]   tel_t,
    output logic [NIB_W-1:0]   tel_p
);

    localparam int SIG_POS = N_COLS * PAIRS + 1;

    logic             sig_hit;
    logic [POS_W-1:0] pos;

    sfa_sig_detect u_sig_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .in_byte_i  (in_byte),
        .sig_hit_o  (sig_hit)
    );

    sfa_lock_ctrl #(
        .FRAME_BYTES (FRAME_BYTES),
        .SIG_POS     (SIG_POS),
        .MISS_LIMIT  (MISS_LIMIT),
        .POS_W       (POS_W)
    ) u_lock_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .sig_hit_i  (sig_hit),
        .pos_o      (pos),
        .locked_o   (locked)
    );

    sfa_unpack #(
        .N_COLS (N_COLS),
        .PAIRS  (PAIRS),
        .POS_W  (POS_W),
        .COL_W  (COL_W),
        .ROW_W  (ROW_W),
        .NIB_W  (NIB_W)
    ) u_unpack (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid_i   (in_valid),
        .in_byte_i    (in_byte),
        .pos_i        (pos),
        .locked_i     (locked),
        .px_valid_o   (px_valid),
        .px_odd_o     (px_odd),
        .px_even_o    (px_even),
        .row_odd_o    (row_odd),
        .row_even_o   (row_even),
        .col_o        (col),
        .frame_done_o (frame_done),
        .tel_r_o      (tel_r),
        .tel_n_o      (tel_n),
        .tel_t_o      (tel_t),
        .tel_p_o      (tel_p)
    );

endmodule

// File: tb/sweep_frame_aligner_bench.sv
`timescale 1ns/1ps
module sweep_frame_aligner_bench;

    localparam int IMG   = 1120;
    localparam int FRAME = 1124;

    // Frame table: {filler1[19:12], filler2[11:4], exp_lock[3], exp_done[2], exp_px[1], gaps[0]}
    localparam logic [19:0] FRAMES [10] = '{
        {8'hE0, 8'hF0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'hF0, 8'hE0, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'hE8, 8'hE0, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'hE0, 8'hE0, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'hE0, 8'h60, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'hF0, 8'hF0, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'hE1, 8'hE0, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'hE0, 8'hE4, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'hE0, 8'hE0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hE0, 8'hE0, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       locked, px_valid, frame_done;
    logic [3:0] px_odd, px_even, row_odd, row_even;
    logic [8:0] col;
    logic [3:0] tel_r, tel_n, tel_t, tel_p;

    int checks = 0;
    int errors = 0;
    int px_cnt, pix_err, done_cnt, done_err, gap_err;

    always #2 clk = ~clk;

    sweep_frame_aligner u_sweep_frame_aligner (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .locked(locked), .px_valid(px_valid), .px_odd(px_odd), .px_even(px_even),
        .row_odd(row_odd), .row_even(row_even), .col(col), .frame_done(frame_done),
        .tel_r(tel_r), .tel_n(tel_n), .tel_t(tel_t), .tel_p(tel_p)
    );

    function automatic logic [7:0] img_byte(input int f, input int p);
        logic [3:0] o, e;
        o = 4'((p * 3 + f) % 16);
        e = 4'((p % 15) + 1);
        return {o, e};
    endfunction

    function automatic logic [7:0] tel_a(input int f);
        return {4'((f + 3) % 16), 4'((f % 7) + 1)};
    endfunction

    function automatic logic [7:0] tel_b(input int f);
        return {4'((f * 5 + 2) % 16), 4'((f % 5) + 9)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        px_cnt = 0; pix_err = 0; done_cnt = 0; done_err = 0; gap_err = 0;
    endtask

    // Drive one accepted byte and inspect the registered outputs just after the edge (R10).
    task automatic push(input logic [7:0] b, input int p);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        if (px_valid) begin
            px_cnt++;
            if (p >= IMG || col != 9'(p / 4 + 1) || row_odd != 4'(2 * (p % 4) + 1) ||
                row_even != 4'(2 * (p % 4) + 2) || px_odd != b[7:4] || px_even != b[3:0])
                pix_err++;
        end
        if (frame_done) begin
            done_cnt++;
            if (p != FRAME - 1) done_err++;
        end
    endtask

    // Idle cycle carrying a pattern-like byte that must be ignored (R9).
    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hE0;
        @(posedge clk);
        #1;
        if (px_valid || frame_done) gap_err++;
    endtask

    task automatic send_frame(input int f, input logic [7:0] d1, input logic [7:0] d2,
                              input int start, input bit gaps);
        for (int p = start; p < FRAME; p++) begin
            logic [7:0] b;
            if (p < IMG)             b = img_byte(f, p);
            else if (p == IMG)       b = d1;
            else if (p == IMG + 1)   b = d2;
            else if (p == IMG + 2)   b = tel_a(f);
            else                     b = tel_b(f);
            if (gaps && (p % 97 == 5)) begin
                idle_cycle();
                idle_cycle();
            end
            push(b, p);
        end
    endtask

    task automatic check_reset_state(input string when);
        chk(!locked && !px_valid && !frame_done, $sformatf("R1 flags %s", when),
            {locked, px_valid, frame_done}, 0);
        chk({tel_r, tel_n, tel_t, tel_p} == 16'h0, $sformatf("R1 telemetry %s", when),
            {tel_r, tel_n, tel_t, tel_p}, 0);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check_reset_state("at start");
        @(negedge clk);
        rst_n = 1'b1;

        // Enter mid-frame: the tail holds one signature, giving a candidate (R3).
        clear_counts();
        send_frame(40, 8'hE0, 8'hE0, 824, 1'b0);
        chk(!locked, "R3 candidate alone does not lock", locked, 0);
        chk(px_cnt == 0, "R5 no pixels in partial frame", px_cnt, 0);

        // Table walk: acquisition, misses, loss, reacquisition (R2 R3 R4).
        for (int i = 0; i < 10; i++) begin
            logic [19:0] e;
            e = FRAMES[i];
            clear_counts();
            send_frame(i, e[19:12], e[11:4], 0, e[0]);
            chk(locked == e[3], $sformatf("R2 R3 R4 lock after frame %0d", i), locked, e[3]);
            chk(px_cnt == (e[1] ? IMG : 0), $sformatf("R5 pixel count frame %0d", i),
                px_cnt, e[1] ? IMG : 0);
            chk(pix_err == 0, $sformatf("R6 R7 R10 pixel labels frame %0d", i), pix_err, 0);
            chk(done_cnt == int'(e[2]) && done_err == 0,
                $sformatf("R8 done pulse frame %0d", i), done_cnt, e[2]);
            if (e[2])
                chk({tel_r, tel_n, tel_t, tel_p} == {tel_a(i), tel_b(i)},
                    $sformatf("R8 telemetry frame %0d", i),
                    {tel_r, tel_n, tel_t, tel_p}, {tel_a(i), tel_b(i)});
            if (e[0])
                chk(gap_err == 0, $sformatf("R9 idle cycles frame %0d", i), gap_err, 0);
        end

        // Reset while locked.
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_reset_state("while locked");
        @(negedge clk);
        rst_n = 1'b1;

        // False candidate that is never confirmed (R11).
        clear_counts();
        push(8'hE0, 0);
        push(8'hF0, 0);
        for (int k = 0; k < FRAME; k++) push(img_byte(30, k), k + FRAME);
        chk(!locked, "R11 false candidate discarded", locked, 0);
        clear_counts();
        send_frame(31, 8'hE0, 8'hE0, 0, 1'b0);
        chk(!locked, "R11 new candidate after discard", locked, 0);
        chk(px_cnt == 0 && done_cnt == 0, "R5 silent while verifying", px_cnt + done_cnt, 0);
        clear_counts();
        send_frame(32, 8'hE0, 8'hE0, 0, 1'b0);
        chk(locked, "R3 lock after confirmed pair", locked, 1);
        chk(done_cnt == 1, "R8 done on locking frame", done_cnt, 1);
        chk({tel_r, tel_n, tel_t, tel_p} == {tel_a(32), tel_b(32)}, "R8 telemetry after relock",
            {tel_r, tel_n, tel_t, tel_p}, {tel_a(32), tel_b(32)});

        @(negedge clk);
        in_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule